// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block is the hardwired control unit of a small single-bus processor. A step counter counts through the control steps of the current instruction. Its value is decoded into a one-hot step vector, in which bit 0 is the first step (fetch). The current opcode is decoded into one signal per instruction. Fixed combinational equations then join the step signals, the instruction signals and the negative flag to drive two datapath strobes. These are the Z-register load strobe and the end-of-instruction strobe.

Instructions of different lengths share one counter. The end-of-instruction strobe acts as a synchronous clear back to the fetch step. A low `run` input freezes the counter, so a slow memory access can hold the current step. The conditional jump takes a different number of steps depending on the negative flag.

The opcode and flag are plain level inputs. They are expected to stay stable while an instruction runs, as they would when driven from an instruction register. Every output is a plain control signal with no handshake.

Top module: `ctl_step_seq`

## Requirements
- R1: An asynchronous reset (rst_n low) puts the sequencer in the fetch step: `step` equals 7'b0000001.
- R2: Exactly one bit of `step` is 1 in every cycle.
- R3: With `run`=1 and `done`=0, the next rising edge moves the active bit of `step` one position up. Bit k is step T(k+1).
- R4: With `run`=0, the next rising edge leaves `step` unchanged, even while `done` is 1.
- R5: With `run`=1 and `done`=1, the next rising edge returns `step` to T1 (bit 0).
- R6: `zin` is 1 in T1 for every opcode. It is also 1 in T6 when opcode is add (2'b00), and in T5 when opcode is jump (2'b01) or jump-if-negative (2'b10). It is 0 in every other case.
- R7: For opcode 2'b00 (add), `done` is 1 only in T7, so the instruction takes 7 steps.
- R8: For opcode 2'b01 (jump), `done` is 1 only in T6.
- R9: For opcode 2'b10 (jump-if-negative), `done` is 1 only in T4 when `neg_flag`=0, and only in T6 when `neg_flag`=1.
- R10: For the unused opcode 2'b11, `done` is 1 only in T4, so execution returns to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 2 | Opcode of the current instruction |
| neg_flag | input | 1 | Negative flag from the datapath |
| run | input | 1 | 1 lets the step counter advance; 0 holds it |
| step | output | 7 | One-hot step vector, bit 0 = T1 |
| zin | output | 1 | Z-register load strobe |
| done | output | 1 | End of instruction; clears to fetch |

## Verification
A wrong counter state shows up in `step` in the same cycle, because the decoder is purely combinational. It also moves `zin` and `done` to the wrong step, so the instruction becomes longer or shorter. One missed clear or one extra increment leaves every later step of that instruction off by one. A lost stall shows up on the first edge with `run` low. The sweep covers every opcode, both flag values, and several stall patterns. Each cycle is compared against a step position computed from the instruction length.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;
  localparam int OPC_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 2'b00,
    OPC_JMP  = 2'b01,
    OPC_JMPN = 2'b10,
    OPC_RSVD = 2'b11
  } opc_e;

  typedef struct packed {
    logic is_add;
    logic is_jmp;
    logic is_jmpn;
    logic is_rsvd;
  } insn_t;
endpackage

// File: rtl/seq_step_counter.sv
module seq_step_counter #(
  parameter int NSTEPS = 7,
  localparam int CW = (NSTEPS > 1) ? $clog2(NSTEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(NSTEPS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run) begin
      if (clr || cnt == LAST) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seq_step_decoder.sv
module seq_step_decoder #(
  parameter int NSTEPS = 7,
  localparam int CW = (NSTEPS > 1) ? $clog2(NSTEPS) : 1
) (
  input  logic [CW-1:0]     cnt,
  output logic [NSTEPS-1:0] t
);
  for (genvar i = 0; i < NSTEPS; i++) begin : g_step
    assign t[i] = (cnt == CW'(i));
  end
endmodule

// File: rtl/seq_insn_decoder.sv
module seq_insn_decoder
  import seqctl_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output insn_t            insn
);
  always_comb begin
    insn = '0;
    case (opc_e'(opc))
      OPC_ADD:  insn.is_add  = 1'b1;
      OPC_JMP:  insn.is_jmp  = 1'b1;
      OPC_JMPN: insn.is_jmpn = 1'b1;
      default:  insn.is_rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/seq_ctl_encoder.sv
module seq_ctl_encoder
  import seqctl_pkg::*;
#(
  parameter int NSTEPS = 7
) (
  input  logic [NSTEPS-1:0] t,
  input  insn_t             insn,
  input  logic              neg,
  output logic              zin,
  output logic              fin
);
  // Step positions of the sequences; NSTEPS must be at least 7.
  localparam int S_FETCH = 0;
  localparam int S_T4    = 3;
  localparam int S_T5    = 4;
  localparam int S_T6    = 5;
  localparam int S_T7    = 6;

  always_comb begin
    zin = t[S_FETCH]
        | (t[S_T6] & insn.is_add)
        | (t[S_T5] & (insn.is_jmp | insn.is_jmpn));
    fin = (t[S_T7] & insn.is_add)
        | (t[S_T6] & insn.is_jmp)
        | (t[S_T4] & ~neg & insn.is_jmpn)
        | (t[S_T6] & insn.is_jmpn)
        | (t[S_T4] & insn.is_rsvd);
  end
endmodule

// File: rtl/ctl_step_seq.sv
module ctl_step_seq
  import seqctl_pkg::*;
#(
  parameter int NSTEPS = 7,
  localparam int CW = (NSTEPS > 1) ? $clog2(NSTEPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        opcode,
  input  logic              neg_flag,
  input  logic              run,
  output logic [NSTEPS-1:0] step,
  output logic              zin,
  output logic              done
);
  logic [CW-1:0] cnt;
  insn_t         insn;

  seq_step_counter #(.NSTEPS(NSTEPS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(done), .cnt(cnt)
  );

  seq_step_decoder #(.NSTEPS(NSTEPS)) u_tdec (
    .cnt(cnt), .t(step)
  );

  seq_insn_decoder u_idec (
    .opc(opcode), .insn(insn)
  );

  seq_ctl_encoder #(.NSTEPS(NSTEPS)) u_enc (
    .t(step), .insn(insn), .neg(neg_flag), .zin(zin), .fin(done)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int NSTEPS = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [NSTEPS-1:0] step,
  input logic              done
);
  assert_onehot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step) == 1);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (step == ($past(step) << 1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(step));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done) |=> step[0]);

  // R7 R8 R9 R10: an instruction can only end in T4, T6 or T7
  assert_end_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(step[0] | step[1] | step[2] | step[4]));
endmodule

bind ctl_step_seq seq_checker #(.NSTEPS(NSTEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .step(step), .done(done)
);

// File: tb/sim_ctl_step_seq.sv
`timescale 1ns/1ps
module sim_ctl_step_seq;
  localparam int NS = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    opcode = 2'b00;
  logic          neg_flag = 1'b0;
  logic          run = 1'b0;
  logic [NS-1:0] step;
  logic          zin;
  logic          done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ctl_step_seq #(.NSTEPS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .neg_flag(neg_flag),
    .run(run), .step(step), .zin(zin), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int seq_len(input int op, input bit n);
    case (op)
      0: return 7;
      1: return 6;
      2: return n ? 6 : 4;
      default: return 4;
    endcase
  endfunction

  function automatic string end_tag(input int op);
    case (op)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int e;
    string last;
    #1;
    chk("R1", int'(step), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R1", int'(step), 1);
    e = 0;
    last = "R1";
    for (int op = 0; op < 4; op++) begin
      for (int nf = 0; nf < 2; nf++) begin
        for (int pat = 0; pat < 3; pat++) begin
          int len;
          int cyc;
          int adv;
          bit r;
          bit dexp;
          bit zexp;
          len = seq_len(op, bit'(nf));
          cyc = 0;
          adv = 0;
          while (adv < len) begin
            @(negedge clk);
            opcode = 2'(op);
            neg_flag = bit'(nf);
            r = (pat == 0) ? 1'b1 : (pat == 1) ? bit'(cyc % 2) : bit'(cyc % 3 != 0);
            run = r;
            #0.5;
            dexp = (e == len - 1);
            zexp = (e == 0) || (op == 0 && e == 5) || ((op == 1 || op == 2) && e == 4);
            chk(last, int'(step), 1 << e);
            chk("R2", $countones(step), 1);
            chk("R6", int'(zin), int'(zexp));
            chk(end_tag(op), int'(done), int'(dexp));
            @(posedge clk);
            if (r) begin
              adv++;
              if (dexp) begin e = 0; last = "R5"; end
              else begin e = e + 1; last = "R3"; end
            end else begin
              last = "R4";
            end
            cyc++;
          end
        end
      end
    end
    // stall while END is pending must hold the final step (R4)
    @(negedge clk);
    opcode = 2'b11; run = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b0;
    #0.5;
    chk("R10", int'(done), 1);
    @(negedge clk);
    #0.5;
    chk("R4", int'(step), 1 << 3);
    run = 1'b1;
    @(negedge clk);
    #0.5;
    chk("R5", int'(step), 1);
    // asynchronous reset mid-instruction
    opcode = 2'b00;
    repeat (2) @(negedge clk);
    #0.5;
    chk("R3", int'(step), 1 << 2);
    rst_n = 1'b0;
    #0.5;
    chk("R1", int'(step), 1);
    @(negedge clk);
    rst_n = 1'b1;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule